// File: doc/BRIEF.md
# Trap-to-CPU Rate Policer

This block sits between the trap logic of a switch and the host CPU path and limits how much trapped traffic gets through. Each trapped packet is presented on a valid/ready stream with its length in bytes. For every packet accepted, the policer returns a verdict in arrival order on a second valid/ready stream. The verdict is pass, drop, or drop-and-mark-red. The policer can meter packets or bytes. It holds a committed credit bucket, and in dual-rate mode a second, exceed bucket. Both buckets are refilled once per fixed 50 ns slice (five cycles of a 100 MHz clock) and both are capped at a burst size that is a power of two.

Configuration arrives on plain pins and takes effect on a one-cycle `cfg_load` pulse. The load also refills both buckets to the new burst cap. Two counters, one for passed packets and one for dropped packets, can be read at any time and are zeroed by `cnt_clr`.

Back-pressure: a packet is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while a verdict is held and not yet taken, and on any cycle where `cfg_load` is high. A verdict is taken on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid`, `out_drop` and `out_red` do not change.

Top module: `trap_policer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and both counters are 0. Until the first `cfg_load`, the buckets are empty, so every packet is dropped.
- R2: With `cfg_bytes`=0, each packet costs one credit. The burst cap is 2^`cfg_cbs` credits, but a `cfg_cbs` below 3 gives a cap of 8. With a zero rate, exactly the cap's worth of packets pass after a load.
- R3: With `cfg_bytes`=1, a packet costs `in_len` credits. A packet passes only if the committed bucket holds at least its cost. A denied packet leaves the bucket unchanged, so a later smaller packet that fits still passes.
- R4: Every 5 cycles (one slice), each bucket gains `rate`×K/2^32 credits, and the result saturates at the cap. K is the rate-per-slice factor: 215 in packet mode, 214748 in byte mode with the kilo unit, and 214748365 in byte mode with the mega unit. The slice timer restarts on `cfg_load`.
- R5: Credit is kept in fixed point with 32 fraction bits. A rate worth less than one credit per slice therefore still accumulates over many slices.
- R6: In byte mode, `cfg_unit_k`=1 scales rates by 10^3 and `cfg_unit_k`=0 scales them by 10^6.
- R7: With `cfg_dual`=0, a packet that does not fit the committed bucket gets the violate action. `cfg_eir` and the exceed action have no effect in this mode.
- R8: With `cfg_dual`=1, a packet that misses the committed bucket but fits the exceed bucket gets the exceed action. A packet that fits neither gets the violate action. A conforming packet debits both buckets, provided the exceed bucket can cover it.
- R9: Action code 1 means discard (`out_drop`=1, `out_red`=0). Code 2 means mark red, and because the destination is the CPU the packet is also dropped (`out_drop`=1, `out_red`=1). Any other code acts as discard. A passing packet shows `out_drop`=0 and `out_red`=0.
- R10: Verdicts come out one per accepted packet, in order, the cycle after acceptance. A verdict stays stable while `out_ready` is low, and `in_ready` is low during that time.
- R11: `cfg_load` refills both buckets to the new cap. It does not change a verdict already waiting at the output.
- R12: `cnt_pass` and `cnt_drop` count verdicts as packets are accepted. `cnt_clr` zeroes both counters and takes priority over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Trapped packet present |
| in_ready | output | 1 | Policer can take a packet |
| in_len | input | LEN_W | Packet length in bytes |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_drop | output | 1 | Verdict: packet dropped |
| out_red | output | 1 | Verdict: packet marked red |
| cfg_load | input | 1 | Apply configuration pins, refill buckets |
| cfg_bytes | input | 1 | 0 meter packets, 1 meter bytes |
| cfg_unit_k | input | 1 | Byte-rate unit, 1 kilo, 0 mega |
| cfg_dual | input | 1 | 0 single-rate, 1 dual-rate |
| cfg_cir | input | RATE_W | Committed rate |
| cfg_eir | input | RATE_W | Exceed rate |
| cfg_cbs | input | CBS_W | Burst exponent |
| cfg_exc_act | input | ACT_W | Action for the exceed band |
| cfg_vio_act | input | ACT_W | Action above all limits |
| cnt_clr | input | 1 | Zero both counters |
| cnt_pass | output | CNT_W | Passed packet count |
| cnt_drop | output | CNT_W | Dropped packet count |

## Verification
The bench first drains buckets that have a zero rate and checks the exact burst size, including the floor of 8 at small exponents. A design that ignored the floor would pass only one or two packets. In byte mode it sends a large packet that is refused and then a smaller one that fits. A design that debited on refusal would drop the smaller one. A long run at one tenth of a credit per slice separates true fixed-point accumulation from a design that truncates credit to whole units, which would pass only the initial burst. Further tests show that the kilo and mega units give rates about a thousandfold apart, that dual-rate traffic splits between the exceed and violate actions, and that a verdict held under back-pressure survives a configuration load unchanged.

// File: rtl/tpol_pkg.sv
`timescale 1ns/1ps
package tpol_pkg;

  localparam int FRAC_W   = 32;
  localparam int CLK_NS   = 10;
  localparam int SLICE_NS = 50;

  typedef enum logic [3:0] {
    ACT_DISCARD  = 4'd1,
    ACT_MARK_RED = 4'd2
  } act_e;

  // rate units per second -> fixed-point credit per slice, rounded
  function automatic logic [63:0] slice_factor(input logic [63:0] scale);
    logic [127:0] num;
    num = (128'(scale) * 128'(SLICE_NS)) << FRAC_W;
    return 64'((num + 128'd500_000_000) / 128'd1_000_000_000);
  endfunction

  localparam logic [63:0] K_PKT  = slice_factor(64'd1);
  localparam logic [63:0] K_KILO = slice_factor(64'd1_000);
  localparam logic [63:0] K_MEGA = slice_factor(64'd1_000_000);

  // {drop, red}
  function automatic logic [1:0] act_decode(input logic [3:0] code);
    return {1'b1, code == ACT_MARK_RED};
  endfunction

endpackage

// File: rtl/tpol_scale.sv
`timescale 1ns/1ps
module tpol_scale import tpol_pkg::*; #(
  parameter int RATE_W = 32,
  parameter int CRED_W = 64
) (
  input  logic [RATE_W-1:0] rate,
  input  logic              bytes,
  input  logic              unit_k,
  output logic [CRED_W-1:0] credit
);
  logic [CRED_W-1:0] factor;

  always_comb begin
    if (!bytes)      factor = CRED_W'(K_PKT);
    else if (unit_k) factor = CRED_W'(K_KILO);
    else             factor = CRED_W'(K_MEGA);
    credit = CRED_W'(rate) * factor;
  end
endmodule

// File: rtl/tpol_bucket.sv
`timescale 1ns/1ps
module tpol_bucket #(
  parameter int FX_W   = 96,
  parameter int CRED_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              tick,
  input  logic              take,
  input  logic [FX_W-1:0]   cap_now,
  input  logic [FX_W-1:0]   cap_load,
  input  logic [FX_W-1:0]   cost,
  input  logic [CRED_W-1:0] credit,
  output logic              fits
);
  logic [FX_W-1:0] level;
  logic [FX_W:0]   after_take, after_fill;

  assign fits = level >= cost;

  always_comb begin
    after_take = {1'b0, level} - ((take && fits) ? {1'b0, cost} : '0);
    after_fill = tick ? after_take + (FX_W+1)'(credit) : after_take;
    if (after_fill > {1'b0, cap_now}) after_fill = {1'b0, cap_now};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    level <= '0;
    else if (load) level <= cap_load;
    else           level <= after_fill[FX_W-1:0];
  end

  AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |-> level <= cap_now); // R2
  AST_DENY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !fits && !tick && !load) |=> level == $past(level)); // R3
endmodule

// File: rtl/trap_policer.sv
`timescale 1ns/1ps
module trap_policer import tpol_pkg::*; #(
  parameter int RATE_W = 32,
  parameter int LEN_W  = 16,
  parameter int CBS_W  = 6,
  parameter int CNT_W  = 32,
  parameter int ACT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_drop,
  output logic              out_red,
  input  logic              cfg_load,
  input  logic              cfg_bytes,
  input  logic              cfg_unit_k,
  input  logic              cfg_dual,
  input  logic [RATE_W-1:0] cfg_cir,
  input  logic [RATE_W-1:0] cfg_eir,
  input  logic [CBS_W-1:0]  cfg_cbs,
  input  logic [ACT_W-1:0]  cfg_exc_act,
  input  logic [ACT_W-1:0]  cfg_vio_act,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_pass,
  output logic [CNT_W-1:0]  cnt_drop
);
  localparam int LVL_W  = 1 << CBS_W;
  localparam int FX_W   = LVL_W + FRAC_W;
  localparam int CRED_W = RATE_W + 32;
  localparam int SL_CYC = SLICE_NS / CLK_NS;
  localparam int SL_W   = (SL_CYC > 1) ? $clog2(SL_CYC) : 1;
  localparam logic [CBS_W-1:0] CBS_FLOOR = CBS_W'(3);

  // latched configuration
  logic              bytes_q, unit_k_q, dual_q;
  logic [RATE_W-1:0] cir_q, eir_q;
  logic [CBS_W-1:0]  cbs_q;
  logic [ACT_W-1:0]  exc_q, vio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bytes_q <= 1'b0; unit_k_q <= 1'b0; dual_q <= 1'b0;
      cir_q <= '0; eir_q <= '0; cbs_q <= '0;
      exc_q <= ACT_W'(ACT_DISCARD); vio_q <= ACT_W'(ACT_DISCARD);
    end else if (cfg_load) begin
      bytes_q <= cfg_bytes; unit_k_q <= cfg_unit_k; dual_q <= cfg_dual;
      cir_q <= cfg_cir; eir_q <= cfg_eir; cbs_q <= cfg_cbs;
      exc_q <= cfg_exc_act; vio_q <= cfg_vio_act;
    end
  end

  // slice timer
  logic [SL_W-1:0] slice_cnt;
  logic            tick;
  assign tick = (slice_cnt == SL_W'(SL_CYC - 1)) && !cfg_load;

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_load || tick) slice_cnt <= '0;
    else                            slice_cnt <= slice_cnt + 1'b1;
  end

  // burst caps and packet cost
  logic [CBS_W-1:0] cbs_now_eff, cbs_new_eff;
  logic [FX_W-1:0]  cap_now, cap_load, cost_fx;

  always_comb begin
    cbs_now_eff = (cbs_q   < CBS_FLOOR) ? CBS_FLOOR : cbs_q;
    cbs_new_eff = (cfg_cbs < CBS_FLOOR) ? CBS_FLOOR : cfg_cbs;
    cap_now  = FX_W'(1) << (32'(cbs_now_eff) + FRAC_W);
    cap_load = FX_W'(1) << (32'(cbs_new_eff) + FRAC_W);
    cost_fx  = bytes_q ? (FX_W'(in_len) << FRAC_W) : (FX_W'(1) << FRAC_W);
  end

  // stream handshake
  logic accept;
  assign in_ready = (!out_valid || out_ready) && !cfg_load;
  assign accept   = in_valid && in_ready;

  // committed (0) and exceed (1) buckets
  logic [RATE_W-1:0] rate_sel [2];
  logic [CRED_W-1:0] credit   [2];
  logic [1:0]        fits, take;

  assign rate_sel[0] = cir_q;
  assign rate_sel[1] = eir_q;
  assign take[0]     = accept && fits[0];
  assign take[1]     = accept && dual_q;

  for (genvar g = 0; g < 2; g++) begin : g_bkt
    tpol_scale #(.RATE_W(RATE_W), .CRED_W(CRED_W)) u_scale (
      .rate(rate_sel[g]), .bytes(bytes_q), .unit_k(unit_k_q), .credit(credit[g])
    );
    tpol_bucket #(.FX_W(FX_W), .CRED_W(CRED_W)) u_bucket (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .tick(tick), .take(take[g]),
      .cap_now(cap_now), .cap_load(cap_load), .cost(cost_fx),
      .credit(credit[g]), .fits(fits[g])
    );
  end

  // verdict
  logic v_drop, v_red;
  always_comb begin
    {v_drop, v_red} = 2'b00;
    if (!fits[0]) begin
      if (dual_q && fits[1]) {v_drop, v_red} = act_decode(exc_q);
      else                   {v_drop, v_red} = act_decode(vio_q);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_drop <= 1'b0; out_red <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1; out_drop <= v_drop; out_red <= v_red;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cnt_clr) begin
      cnt_pass <= '0; cnt_drop <= '0;
    end else if (accept) begin
      if (v_drop) cnt_drop <= cnt_drop + 1'b1;
      else        cnt_pass <= cnt_pass + 1'b1;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_drop) && $stable(out_red)); // R10
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R10
  AST_RED_IS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_red) |-> out_drop); // R9
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_pass == '0) && (cnt_drop == '0)); // R12
  AST_SINGLE_NO_EXCEED: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_q |-> !take[1]); // R7
endmodule

// File: tb/trap_policer_tb_top.sv
`timescale 1ns/1ps
module trap_policer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_len = 16'd1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_drop, out_red;
  logic        cfg_load = 1'b0, cfg_bytes = 1'b0, cfg_unit_k = 1'b0, cfg_dual = 1'b0;
  logic [31:0] cfg_cir = '0, cfg_eir = '0;
  logic [5:0]  cfg_cbs = '0;
  logic [3:0]  cfg_exc_act = 4'd1, cfg_vio_act = 4'd1;
  logic        cnt_clr = 1'b0;
  logic [31:0] cnt_pass, cnt_drop;

  int checks = 0, errors = 0;
  int mon_pass = 0, mon_drop = 0, mon_red = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trap_policer dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_drop(out_drop), .out_red(out_red),
    .cfg_load(cfg_load), .cfg_bytes(cfg_bytes), .cfg_unit_k(cfg_unit_k), .cfg_dual(cfg_dual),
    .cfg_cir(cfg_cir), .cfg_eir(cfg_eir), .cfg_cbs(cfg_cbs),
    .cfg_exc_act(cfg_exc_act), .cfg_vio_act(cfg_vio_act),
    .cnt_clr(cnt_clr), .cnt_pass(cnt_pass), .cnt_drop(cnt_drop)
  );

  // verdict monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (out_drop) mon_drop++; else mon_pass++;
      if (out_red)  mon_red++;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog act %0d exp %0d", cyc, 150000);
      summary();
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input bit bytes, input bit unit_k, input bit dual,
                         input int cir, input int eir, input int cbs,
                         input int exc, input int vio);
    @(negedge clk);
    cfg_bytes = bytes; cfg_unit_k = unit_k; cfg_dual = dual;
    cfg_cir = 32'(cir); cfg_eir = 32'(eir); cfg_cbs = 6'(cbs);
    cfg_exc_act = 4'(exc); cfg_vio_act = 4'(vio);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic send_one(input int len, output bit drop, output bit red);
    in_valid = 1'b1; in_len = 16'(len);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    drop = out_drop; red = out_red;
  endtask

  task automatic burst(input int n, input int gap, input int len);
    in_len = 16'(len);
    if (gap <= 1) begin
      @(negedge clk); in_valid = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk); in_valid = 1'b0;
    end else begin
      repeat (n) begin
        @(negedge clk); in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); in_valid = 1'b0;
        repeat (gap - 2) @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic mon_reset();
    @(negedge clk);
    mon_pass = 0; mon_drop = 0; mon_red = 0;
  endtask

  // {reload, bytes, cbs[5:0], len[15:0], expect_drop}; zero rates
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b0},
    {1'b0, 1'b0, 6'd1,  16'd1,   1'b1},
    {1'b1, 1'b1, 6'd10, 16'd300, 1'b0},
    {1'b0, 1'b1, 6'd10, 16'd300, 1'b0},
    {1'b0, 1'b1, 6'd10, 16'd300, 1'b0},
    {1'b0, 1'b1, 6'd10, 16'd300, 1'b1},
    {1'b0, 1'b1, 6'd10, 16'd100, 1'b0},
    {1'b0, 1'b1, 6'd10, 16'd24,  1'b0},
    {1'b0, 1'b1, 6'd10, 16'd1,   1'b1}
  };

  initial begin
    bit d, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(cnt_pass == 0 && cnt_drop == 0, "R1 counters", cnt_pass + cnt_drop, 0);
    send_one(1, d, r);
    check(d == 1'b1, "R1 drop before load", d, 1);

    // R2 R3 zero-rate burst table
    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      if (v[24]) do_load(v[23], 1'b0, 1'b0, 0, 0, int'(v[22:17]), 1, 1);
      send_one(int'(v[16:1]), d, r);
      check(d == v[0] && r == 1'b0, v[23] ? "R3 byte table" : "R2 packet table",
            {d, r}, {v[0], 1'b0});
    end

    // R11 load refills the bucket (byte bucket is empty now)
    do_load(1'b1, 1'b0, 1'b0, 0, 0, 10, 1, 1);
    send_one(1024, d, r);
    check(d == 1'b0, "R11 refill on load", d, 0);

    // R10 R11 back-pressure and load under a held verdict
    do_load(1'b0, 1'b0, 1'b0, 0, 0, 3, 1, 1);
    mon_reset();
    out_ready = 1'b0;
    in_valid = 1'b1; in_len = 16'd1;
    @(posedge clk);
    @(negedge clk);
    check(out_valid && !out_drop, "R10 verdict after one cycle", {out_valid, out_drop}, 2'b10);
    check(in_ready == 1'b0, "R10 in_ready low while held", in_ready, 0);
    cfg_vio_act = 4'd2; cfg_cbs = 6'd3; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    check(out_valid && !out_drop && !out_red, "R11 held verdict untouched",
          {out_valid, out_drop, out_red}, 3'b100);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(mon_pass == 2, "R10 both verdicts delivered", mon_pass, 2);

    // R12 counters and clear
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    check(cnt_pass == 0 && cnt_drop == 0, "R12 clear", cnt_pass + cnt_drop, 0);

    // R4 R7 single rate ~1 credit per slice, eir and exceed action ignored
    do_load(1'b0, 1'b0, 1'b0, 20_000_000, 2_000_000_000, 3, 2, 1);
    repeat (200) @(negedge clk);
    mon_reset();
    burst(40, 1, 1);
    check(mon_pass >= 14 && mon_pass <= 18, "R4 refill rate", mon_pass, 16);
    check(mon_red == 0, "R7 single rate no exceed action", mon_red, 0);
    check(cnt_pass == 32'(mon_pass) && cnt_drop == 32'(mon_drop), "R12 counters match",
          cnt_pass, mon_pass);

    // R5 fractional credit: 0.1 per slice
    do_load(1'b0, 1'b0, 1'b0, 2_000_000, 0, 3, 1, 1);
    mon_reset();
    burst(500, 10, 1);
    check(mon_pass >= 104 && mon_pass <= 112, "R5 fractional accumulation", mon_pass, 108);

    // R6 byte units
    do_load(1'b1, 1'b0, 1'b0, 20, 0, 3, 1, 1);
    repeat (100) @(negedge clk);
    mon_reset();
    burst(40, 1, 1);
    check(mon_pass >= 14 && mon_pass <= 18, "R6 mega unit", mon_pass, 16);
    do_load(1'b1, 1'b1, 1'b0, 20, 0, 3, 1, 1);
    repeat (100) @(negedge clk);
    mon_reset();
    burst(40, 1, 1);
    check(mon_pass == 8, "R6 kilo unit", mon_pass, 8);

    // R8 R9 dual rate: exceed action red, violate action discard
    do_load(1'b0, 1'b0, 1'b1, 0, 20_000_000, 3, 2, 1);
    mon_reset();
    burst(8, 1, 1);
    check(mon_pass == 8, "R8 committed burst", mon_pass, 8);
    repeat (100) @(negedge clk);
    send_one(1, d, r);
    check(d && r, "R9 exceed band marked red", {d, r}, 2'b11);
    mon_reset();
    burst(20, 1, 1);
    check(mon_pass == 0, "R8 no pass over committed", mon_pass, 0);
    check(mon_red >= 1, "R8 exceed band present", mon_red, 10);
    check(mon_drop - mon_red >= 1, "R9 violate discards unmarked", mon_drop - mon_red, 9);

    done = 1'b1;
    summary();
  end
endmodule